// File: doc/BRIEF.md
# Dual Smart-Card Clock and Contact Router

This block serves two smart-card slots from one controller-side interface. Each slot has its own card clock. That clock is made from one of two input clocks, chosen per slot, divided by 1, 2, 4 or 8. Each clock can also be parked low or parked high. All of this runs in a single system clock domain. The two input clocks are sampled, and every change of level on the chosen input counts as one source edge.

The reset, C4 and C8 contact lines reach the cards through registers, and those registers load only while the active-low chip select is asserted. In normal mode each slot takes its own input pins. In shared-pin mode, the slot A input pins drive whichever slot the card-select bit names. The other slot keeps its last values, and the slot B input pins are ignored.

The block also drives one pull-up enable for each contact input pin. Software programs each slot through a 5-bit word. The word is written on a strobe while chip select is low, and the card-select bit picks the slot it goes to.

Top module: `card_if_router`

## Requirements
- R1: While running, a slot's card clock toggles once every 2^r source edges (rising or falling) of its chosen input clock, where r is prog_data[1:0] (00 = /1, 01 = /2, 10 = /4, 11 = /8).
- R2: Field prog_data[3:2] sets the stop mode: 00 or 01 = run, 10 = park low, 11 = park high. A parked clock reaches the requested level at the end of the current half period and then holds it. When the slot returns to run, the clock restarts from that level.
- R3: Bit prog_data[4] selects the slot's source (0 = clk_in_a, 1 = clk_in_b). Any slot can use either source, and this does not depend on mux_mode.
- R4: The contact outputs (card_rst, card_c4, card_c8) change only on a clock edge at which cs_n was low. While cs_n is high they hold their values.
- R5: With mux_mode low and cs_n low, slot A outputs take rst_a/c4_a/c8_a and slot B outputs take rst_b/c4_b/c8_b, one cycle later.
- R6: With mux_mode high and cs_n low, rst_a/c4_a/c8_a drive slot B when card_sel = 1 and slot A when card_sel = 0. The unselected slot holds its values, and rst_b/c4_b/c8_b have no effect.
- R7: pu_en bit order is [0] rst_a, [1] c4_a, [2] c8_a, [3] rst_b, [4] c4_b, [5] c8_b. With mux_mode low, every bit follows pu_req one cycle later.
- R8: With mux_mode high, pu_en[5] is 1 one cycle later, whatever the value of pu_req.
- R9: A change of ratio or stop mode takes effect only at a half-period boundary of the card clock. Every half period lasts either the old length or the new one, so no runt pulse appears.
- R10: A program word is stored only when prog_we = 1 and cs_n = 0, and it goes to slot card_sel. After rst, both slots are set to ratio /1, source clk_in_a and parked low, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_in_a | input | 1 | First input clock (sampled) |
| clk_in_b | input | 1 | Second input clock (sampled) |
| cs_n | input | 1 | Active-low chip select |
| mux_mode | input | 1 | Shared-pin mode |
| card_sel | input | 1 | Slot select: 0 = A, 1 = B |
| pu_req | input | 1 | Pull-up enable request |
| prog_we | input | 1 | Program write strobe |
| prog_data | input | 5 | {source, stop[1:0], ratio[1:0]} |
| rst_a | input | 1 | Slot A reset input |
| c4_a | input | 1 | Slot A C4 input |
| c8_a | input | 1 | Slot A C8 input |
| rst_b | input | 1 | Slot B reset input |
| c4_b | input | 1 | Slot B C4 input |
| c8_b | input | 1 | Slot B C8 input |
| card_clk | output | 2 | Card clocks, [0] = A, [1] = B |
| card_rst | output | 2 | Card reset lines |
| card_c4 | output | 2 | Card C4 lines |
| card_c8 | output | 2 | Card C8 lines |
| pu_en | output | 6 | Pull-up enables, one per contact input |

## Verification
The assertions assume that both input clocks are synchronous to clk and change level at most once per cycle. Under that assumption, each sampled level change is exactly one source edge, and every card clock transition can be tied to the divider's terminal count in the cycle before. They also assume that control inputs are stable across each rising edge. The bench meets both assumptions: it toggles the input clocks every two and every three cycles, and it moves every input one nanosecond after a rising edge. The half-period checks change the source or ratio only when measuring a transition between two known lengths.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int RATIO_W = 2;

  typedef enum logic [1:0] {
    STOP_RUN     = 2'b00,
    STOP_RUN_ALT = 2'b01,
    STOP_LOW     = 2'b10,
    STOP_HIGH    = 2'b11
  } stop_e;

  typedef struct packed {
    logic               src;
    stop_e              stop;
    logic [RATIO_W-1:0] ratio;
  } slot_cfg_t;

  localparam int CFG_W = $bits(slot_cfg_t);
endpackage

// File: rtl/ccr_clk_div.sv
module ccr_clk_div
  import ccr_pkg::*;
#(
  parameter int CNT_W = (1 << RATIO_W) - 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src_edge,
  input  slot_cfg_t  cfg,
  output logic       ck_out
);
  logic [RATIO_W-1:0] ratio_act;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   lim;
  logic               edge_sel;
  logic               term;
  logic               bnd;
  logic               nxt;

  always_comb begin
    edge_sel = src_edge[cfg.src];
    lim      = CNT_W'((32'd1 << ratio_act) - 32'd1);
    term     = (cnt == lim);
    bnd      = edge_sel && term;
    case (cfg.stop)
      STOP_LOW:  nxt = 1'b0;
      STOP_HIGH: nxt = 1'b1;
      default:   nxt = ~ck_out;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ratio_act <= '0;
      ck_out    <= 1'b0;
    end else if (edge_sel) begin
      if (term) begin
        cnt       <= '0;
        ratio_act <= cfg.ratio;
        ck_out    <= nxt;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: the card clock moves only at a divided-clock boundary
  assert_toggle_on_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(ck_out) |-> $past(bnd));

  // R2: a boundary under park-low leaves the clock low
  assert_park_low_R2: assert property (@(posedge clk) disable iff (rst)
    (bnd && cfg.stop == STOP_LOW) |=> !ck_out);

  // R2: a boundary under park-high leaves the clock high
  assert_park_high_R2: assert property (@(posedge clk) disable iff (rst)
    (bnd && cfg.stop == STOP_HIGH) |=> ck_out);

  // R1: the edge counter never passes the active ratio limit
  assert_count_limit_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim);
endmodule

// File: rtl/ccr_router.sv
module ccr_router #(
  parameter int NPIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              mux_mode,
  input  logic              card_sel,
  input  logic              pu_req,
  input  logic [NPIN-1:0]   pins_a,
  input  logic [NPIN-1:0]   pins_b,
  output logic [NPIN-1:0]   out_a,
  output logic [NPIN-1:0]   out_b,
  output logic [2*NPIN-1:0] pu_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_a <= '0;
      out_b <= '0;
      pu_en <= '0;
    end else begin
      pu_en[NPIN-1:0]      <= {NPIN{pu_req}};
      pu_en[2*NPIN-2:NPIN] <= {(NPIN-1){pu_req}};
      pu_en[2*NPIN-1]      <= pu_req | mux_mode;
      if (!cs_n) begin
        if (!mux_mode) begin
          out_a <= pins_a;
          out_b <= pins_b;
        end else if (card_sel) begin
          out_b <= pins_a;
        end else begin
          out_a <= pins_a;
        end
      end
    end
  end

  // R4: chip select high freezes both slots' contacts
  assert_hold_no_cs_R4: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(out_a) && $stable(out_b)));

  // R6: in shared mode the unselected slot keeps its values
  assert_unsel_hold_a_R6: assert property (@(posedge clk) disable iff (rst)
    (mux_mode && card_sel) |=> $stable(out_a));
  assert_unsel_hold_b_R6: assert property (@(posedge clk) disable iff (rst)
    (mux_mode && !card_sel) |=> $stable(out_b));

  // R8: shared mode forces the slot B C8 pull-up
  assert_c8b_pullup_R8: assert property (@(posedge clk) disable iff (rst)
    mux_mode |=> pu_en[2*NPIN-1]);
endmodule

// File: rtl/card_if_router.sv
module card_if_router
  import ccr_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int NPIN  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_in_a,
  input  logic             clk_in_b,
  input  logic             cs_n,
  input  logic             mux_mode,
  input  logic             card_sel,
  input  logic             pu_req,
  input  logic             prog_we,
  input  logic [CFG_W-1:0] prog_data,
  input  logic             rst_a,
  input  logic             c4_a,
  input  logic             c8_a,
  input  logic             rst_b,
  input  logic             c4_b,
  input  logic             c8_b,
  output logic [NSLOT-1:0] card_clk,
  output logic [NSLOT-1:0] card_rst,
  output logic [NSLOT-1:0] card_c4,
  output logic [NSLOT-1:0] card_c8,
  output logic [2*NPIN-1:0] pu_en
);
  localparam int CNT_W = (1 << RATIO_W) - 1;

  slot_cfg_t  cfg_q [NSLOT];
  logic [1:0] src_prev;
  logic [1:0] src_edge;
  logic [NPIN-1:0] out_a, out_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_prev <= '0;
      for (int i = 0; i < NSLOT; i++)
        cfg_q[i] <= '{src: 1'b0, stop: STOP_LOW, ratio: '0};
    end else begin
      src_prev <= {clk_in_b, clk_in_a};
      if (prog_we && !cs_n)
        cfg_q[card_sel] <= slot_cfg_t'(prog_data);
    end
  end

  assign src_edge = {clk_in_b, clk_in_a} ^ src_prev;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    ccr_clk_div #(.CNT_W(CNT_W)) u_div (
      .clk      (clk),
      .rst      (rst),
      .src_edge (src_edge),
      .cfg      (cfg_q[s]),
      .ck_out   (card_clk[s])
    );

    // R10: configuration holds while chip select is high
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
      cs_n |=> $stable(cfg_q[s]));
  end

  ccr_router #(.NPIN(NPIN)) u_route (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .mux_mode (mux_mode),
    .card_sel (card_sel),
    .pu_req   (pu_req),
    .pins_a   ({c8_a, c4_a, rst_a}),
    .pins_b   ({c8_b, c4_b, rst_b}),
    .out_a    (out_a),
    .out_b    (out_b),
    .pu_en    (pu_en)
  );

  assign card_rst = {out_b[0], out_a[0]};
  assign card_c4  = {out_b[1], out_a[1]};
  assign card_c8  = {out_b[2], out_a[2]};
endmodule

// File: tb/sim_card_if_router.sv
`timescale 1ns/1ps
module sim_card_if_router;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_in_a = 1'b0, clk_in_b = 1'b0;
  logic cs_n = 1'b1, mux_mode = 1'b0, card_sel = 1'b0, pu_req = 1'b0;
  logic prog_we = 1'b0;
  logic [4:0] prog_data = '0;
  logic rst_a = 0, c4_a = 0, c8_a = 0, rst_b = 0, c4_b = 0, c8_b = 0;
  logic [1:0] card_clk, card_rst, card_c4, card_c8;
  logic [5:0] pu_en;

  always #2 clk = ~clk;

  card_if_router u0 (.*);

  int nvec = 0, nbad = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int         due;
    logic [11:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  logic [2:0] ea = '0, eb = '0;
  logic [5:0] epu = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // source clocks: period 4 and 6 system cycles
  initial forever begin repeat (2) @(posedge clk); #1 clk_in_a = ~clk_in_a; end
  initial forever begin repeat (3) @(posedge clk); #1 clk_in_b = ~clk_in_b; end

  // monitor: pops expected contact/pull-up vectors when due
  always @(negedge clk) begin
    cyc++;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      chk(it.req, {20'd0, card_c8[1], card_c4[1], card_rst[1],
                   card_c8[0], card_c4[0], card_rst[0], pu_en}, {20'd0, it.exp});
    end
  end

  function automatic void upd_model(input logic cs, input logic mux, input logic sel,
                                    input logic pu, input logic [2:0] a, input logic [2:0] b);
    if (!cs) begin
      if (!mux) begin ea = a; eb = b; end
      else if (sel) eb = a;
      else ea = a;
    end
    epu = {pu | mux, pu, pu, pu, pu, pu};
  endfunction

  // driver: applies contact stimulus and pushes the expected result
  task automatic apply(input logic cs, input logic mux, input logic sel, input logic pu,
                       input logic [2:0] a, input logic [2:0] b, input string req);
    item_t it;
    @(posedge clk); #1;
    cs_n = cs; mux_mode = mux; card_sel = sel; pu_req = pu;
    {c8_a, c4_a, rst_a} = a; {c8_b, c4_b, rst_b} = b;
    upd_model(cs, mux, sel, pu, a, b);
    it.due = cyc + 2; it.exp = {eb, ea, epu}; it.req = req;
    q.push_back(it);
  endtask

  task automatic prog(input logic slot, input logic [4:0] d, input logic with_cs);
    @(posedge clk); #1;
    card_sel = slot; prog_data = d; prog_we = 1'b1; cs_n = !with_cs;
    upd_model(!with_cs, mux_mode, slot, pu_req, {c8_a, c4_a, rst_a}, {c8_b, c4_b, rst_b});
    @(posedge clk); #1;
    prog_we = 1'b0; cs_n = 1'b1;
  endtask

  task automatic wait_chg(input int s, output int n);
    logic p;
    p = card_clk[s];
    n = 0;
    while (card_clk[s] === p && n < 300) begin @(negedge clk); n++; end
    if (n >= 300) n = -1;
  endtask

  task automatic half_period(input int s, output int h);
    int n;
    @(negedge clk);
    wait_chg(s, n);
    wait_chg(s, h);
  endtask

  initial begin
    int h;
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int h;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (20) @(negedge clk);
    // R10: reset state, clocks parked low, outputs low
    chk("R10 reset clk", {30'd0, card_clk}, 32'd0);
    chk("R10 reset contacts", {20'd0, card_rst, card_c4, card_c8, pu_en}, 32'd0);

    // contact routing
    apply(0, 0, 0, 0, 3'b101, 3'b010, "R5 normal routing");
    apply(1, 0, 0, 1, 3'b011, 3'b111, "R4 hold with cs high / R7 pull-up on");
    apply(0, 0, 0, 1, 3'b110, 3'b001, "R5 normal routing 2");
    apply(0, 1, 1, 0, 3'b111, 3'b000, "R6 shared to slot B / R8");
    apply(0, 1, 1, 0, 3'b010, 3'b111, "R6 slot B pins ignored");
    apply(0, 1, 0, 0, 3'b001, 3'b111, "R6 shared to slot A, B holds");
    apply(0, 1, 0, 1, 3'b001, 3'b110, "R8 pull-ups in shared mode");
    apply(0, 0, 0, 0, 3'b000, 3'b000, "R7 pull-up off in normal mode");
    repeat (4) @(posedge clk);

    // clock paths (data = {src, stop, ratio})
    prog(0, 5'b0_00_00, 1);
    half_period(0, h); chk("R1 slot A /1 src A", h, 2);
    prog(0, 5'b0_00_10, 1);
    repeat (30) @(posedge clk);
    half_period(0, h); chk("R1 slot A /4 src A", h, 8);
    prog(1, 5'b1_00_11, 1);
    repeat (60) @(posedge clk);
    half_period(1, h); chk("R3 slot B /8 src B", h, 24);
    apply(1, 1, 0, 0, 3'b000, 3'b000, "R4 mux set with cs high");
    prog(0, 5'b1_00_01, 1);
    repeat (30) @(posedge clk);
    half_period(0, h); chk("R3 slot A src B in shared mode", h, 6);

    prog(0, 5'b1_10_01, 1);
    repeat (30) @(negedge clk);
    chk("R2 park low level", card_clk[0], 0);
    repeat (30) @(negedge clk);
    chk("R2 park low held", card_clk[0], 0);
    prog(0, 5'b1_11_01, 1);
    repeat (30) @(negedge clk);
    chk("R2 park high level", card_clk[0], 1);
    repeat (30) @(negedge clk);
    chk("R2 park high held", card_clk[0], 1);

    prog(0, 5'b0_00_01, 1);
    repeat (20) @(posedge clk);
    half_period(0, h); chk("R2 restart /2 src A", h, 4);

    // R9: ratio /2 -> /8, every half period old or new length
    prog(0, 5'b0_00_11, 1);
    @(negedge clk);
    wait_chg(0, h);
    for (int i = 0; i < 4; i++) begin
      wait_chg(0, h);
      chk("R9 no runt half period", (h == 4 || h == 16), 1);
    end
    chk("R9 new ratio in force", h, 16);

    // R10: write without chip select is dropped
    prog(0, 5'b0_10_11, 0);
    repeat (40) @(posedge clk);
    half_period(0, h); chk("R10 write ignored without cs", h, 16);
    half_period(1, h); chk("R10 slot B untouched by slot A writes", h, 24);

    repeat (4) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule